// File: doc/BRIEF.md
# Global OR Reduction with Branch Interlock

This block sits in the controller of a wide array of processing elements. It combines one bit from each element through an OR tree. The controller uses the combined bit for parallel branches such as "is any element still enabled". A reduce request does not finish in the cycle it issues. The request first travels down a pipelined distribution tree, which takes `depth + 1` cycles. The gate network then needs a fixed number of reduction cycles, and that number does not shrink when the clock gets faster. Software supplies this number, normally the rounded-up value of twice the clock improvement factor.

When a reduce is accepted, the block loads a down-counter with the full wait, and it captures both configuration values at that moment. When the counter expires, the block samples the OR of the element bits, stores it, and raises a result-valid flag. A branch that depends on the result is held back with an issue stall until the flag is high. Issuing that branch consumes the result. Other instructions keep issuing during the wait, so independent work can fill the slots. A second reduce cannot start while the first result is still unconsumed.

Top module: `gor_branch_interlock`

## Requirements
- R1: After synchronous reset, `result_valid` is 0, `or_result` is 0, and no instruction kind is stalled.
- R2: The stored result is 1 when at least one element bit is set and 0 when none is set. A 0 result means no element is enabled.
- R3: `result_valid` rises exactly `(cfg_depth + 1) + cfg_red_cycles` clock edges after the edge that accepts the reduce. Configuration changes after acceptance do not alter that wait.
- R4: A branch (`issue_kind` = 2'b10) presented while a reduce is pending and the result is not yet valid asserts `issue_stall`. A branch presented on the cycle after the reduce is stalled for exactly `(cfg_depth + 1) + cfg_red_cycles` cycles.
- R5: An instruction of kind other (2'b00, and 2'b11 treated the same) never asserts `issue_stall`, including while a reduce is pending.
- R6: A reduce (`issue_kind` = 2'b01) presented while an earlier reduce is pending or its result is unconsumed asserts `issue_stall`. A reduce presented with nothing pending is accepted at once.
- R7: A branch accepted while `result_valid` is high consumes the result. `result_valid` is 0 on the next cycle, and `or_result` keeps its value until the next reduce completes.
- R8: A branch presented when no reduce is pending never stalls and changes neither `result_valid` nor `or_result`.
- R9: The element bits are sampled on the edge where `result_valid` rises, not on the edge that accepts the reduce.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_bits | input | N_PE | One flag bit from each processing element |
| issue_valid | input | 1 | An instruction is presented for issue this cycle |
| issue_kind | input | 2 | 00 other, 01 reduce, 10 branch, 11 other |
| cfg_depth | input | DEPTH_W | Distribution tree depth d |
| cfg_red_cycles | input | RED_W | Reduction network cycles |
| or_result | output | 1 | Stored OR of the element bits |
| result_valid | output | 1 | Stored result is ready and unconsumed |
| issue_stall | output | 1 | The presented instruction must wait |

## Verification
The bench counts stall cycles for each latency setting, including the largest one and a zero reduction time. An off-by-one in the counter load or in the expiry test would show up as a stall count one too high or one too low. The bench changes the element bits during the wait, which exposes a design that samples them at issue instead of at completion. It also changes the configuration during the wait, which exposes a design that keeps reading live configuration. Further tests fill the wait with other-kind instructions, attempt a second reduce before the first is consumed, and present a branch with nothing pending. These catch a design that stalls the whole controller, that lets a new reduce overwrite an unread result, or that drops the stored result on a stray branch.

// File: rtl/gor_pkg.sv
package gor_pkg;

    typedef enum logic [1:0] {
        KIND_OTHER  = 2'b00,
        KIND_REDUCE = 2'b01,
        KIND_BRANCH = 2'b10,
        KIND_SPARE  = 2'b11
    } issue_kind_e;

    typedef struct packed {
        logic pending;
        logic valid;
        logic result;
    } gor_state_t;

    function automatic int unsigned wait_cycles(int unsigned depth, int unsigned red);
        return depth + 1 + red;
    endfunction

    function automatic int unsigned max_wait(int unsigned depth_w, int unsigned red_w);
        return wait_cycles((1 << depth_w) - 1, (1 << red_w) - 1);
    endfunction

endpackage

// File: rtl/gor_or_tree.sv
module gor_or_tree #(
    parameter int N_PE = 16
) (
    input  logic [N_PE-1:0] bits,
    output logic            any_set
);
    localparam int LEVELS = (N_PE > 1) ? $clog2(N_PE) : 0;
    localparam int P      = 1 << LEVELS;

    logic [2*P-2:0] node;

    genvar i;
    generate
        for (i = 0; i < P; i++) begin : g_leaf
            if (i < N_PE) begin : g_real
                assign node[P-1+i] = bits[i];
            end else begin : g_pad
                assign node[P-1+i] = 1'b0;
            end
        end
        for (i = 0; i < P-1; i++) begin : g_inner
            assign node[i] = node[2*i+1] | node[2*i+2];
        end
    endgenerate

    assign any_set = node[0];
endmodule

// File: rtl/gor_wait_counter.sv
module gor_wait_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = (cnt == CNT_W'(1));

    // R3
    load_captured_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

    // R6
    no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> cnt == '0);
endmodule

// File: rtl/gor_issue_ctl.sv
module gor_issue_ctl
    import gor_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue_valid,
    input  logic [1:0] issue_kind,
    input  logic       pending,
    input  logic       valid,
    output logic       stall,
    output logic       accept_reduce,
    output logic       consume
);
    issue_kind_e kind;
    logic        want_reduce;
    logic        want_branch;

    always_comb begin
        kind          = issue_kind_e'(issue_kind);
        want_reduce   = issue_valid && (kind == KIND_REDUCE);
        want_branch   = issue_valid && (kind == KIND_BRANCH);
        stall         = (want_reduce && pending) || (want_branch && pending && !valid);
        accept_reduce = want_reduce && !pending;
        consume       = want_branch && pending && valid;
    end

    // R5
    other_never_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && (issue_kind == 2'b00 || issue_kind == 2'b11)) |-> !stall);

    // R6
    reduce_and_stall_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(accept_reduce && stall));
endmodule

// File: rtl/gor_branch_interlock.sv
module gor_branch_interlock
    import gor_pkg::*;
#(
    parameter int N_PE    = 16,
    parameter int DEPTH_W = 4,
    parameter int RED_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_PE-1:0]    pe_bits,
    input  logic               issue_valid,
    input  logic [1:0]         issue_kind,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic [RED_W-1:0]   cfg_red_cycles,
    output logic               or_result,
    output logic               result_valid,
    output logic               issue_stall
);
    localparam int MAX_WAIT = int'(max_wait(DEPTH_W, RED_W));
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    gor_state_t       st;
    logic             any_set;
    logic             done;
    logic             accept_reduce;
    logic             consume;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(wait_cycles(int'(cfg_depth), int'(cfg_red_cycles)));

    gor_or_tree #(.N_PE(N_PE)) or_tree_i (
        .bits    (pe_bits),
        .any_set (any_set)
    );

    gor_wait_counter #(.CNT_W(CNT_W)) wait_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept_reduce),
        .load_val (load_val),
        .done     (done)
    );

    gor_issue_ctl ctl_i (
        .clk           (clk),
        .rst           (rst),
        .issue_valid   (issue_valid),
        .issue_kind    (issue_kind),
        .pending       (st.pending),
        .valid         (st.valid),
        .stall         (issue_stall),
        .accept_reduce (accept_reduce),
        .consume       (consume)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (accept_reduce) begin
            st.pending <= 1'b1;
            st.valid   <= 1'b0;
        end else if (done) begin
            st.valid  <= 1'b1;
            st.result <= any_set;
        end else if (consume) begin
            st.pending <= 1'b0;
            st.valid   <= 1'b0;
        end
    end

    assign or_result    = st.result;
    assign result_valid = st.valid;

    // R3
    reduce_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
        accept_reduce |=> !result_valid);

    // R4
    valid_releases_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (result_valid && issue_valid && issue_kind == 2'b10) |-> !issue_stall);

    // R7
    consume_holds_result_chk: assert property (@(posedge clk) disable iff (rst)
        consume |=> !result_valid && $stable(or_result));

    // R8
    idle_branch_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (!st.pending && issue_valid && issue_kind == 2'b10) |=> $stable(or_result) && !result_valid);
endmodule

// File: tb/gor_branch_interlock_tb.sv
module gor_branch_interlock_tb_top;
    localparam logic [1:0] K_OTHER  = 2'b00;
    localparam logic [1:0] K_REDUCE = 2'b01;
    localparam logic [1:0] K_BRANCH = 2'b10;
    localparam logic [1:0] K_SPARE  = 2'b11;

    typedef struct packed {
        logic [3:0]  d;
        logic [3:0]  r;
        logic [15:0] bits;
        logic        hit;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  4'd2,  16'h0000, 1'b0},
        '{4'd0,  4'd2,  16'h0001, 1'b1},
        '{4'd3,  4'd4,  16'h8000, 1'b1},
        '{4'd5,  4'd6,  16'h0000, 1'b0},
        '{4'd15, 4'd15, 16'h0100, 1'b1},
        '{4'd1,  4'd1,  16'hFFFF, 1'b1},
        '{4'd2,  4'd0,  16'h0010, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pe_bits = '0;
    logic        issue_valid = 1'b0;
    logic [1:0]  issue_kind = K_OTHER;
    logic [3:0]  cfg_depth = '0;
    logic [3:0]  cfg_red_cycles = '0;
    logic        or_result;
    logic        result_valid;
    logic        issue_stall;

    int nchk  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    gor_branch_interlock dut_i (
        .clk            (clk),
        .rst            (rst),
        .pe_bits        (pe_bits),
        .issue_valid    (issue_valid),
        .issue_kind     (issue_kind),
        .cfg_depth      (cfg_depth),
        .cfg_red_cycles (cfg_red_cycles),
        .or_result      (or_result),
        .result_valid   (result_valid),
        .issue_stall    (issue_stall)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_reduce(input logic [3:0] d, input logic [3:0] r, input logic [15:0] b);
        cfg_depth      = d;
        cfg_red_cycles = r;
        pe_bits        = b;
        issue_valid    = 1'b1;
        issue_kind     = K_REDUCE;
        #1;
        chk("R6 idle reduce accepted", int'(issue_stall), 0);
        cyc();
    endtask

    task automatic wait_branch(output int stalls);
        stalls      = 0;
        issue_valid = 1'b1;
        issue_kind  = K_BRANCH;
        #1;
        while (issue_stall && stalls < 200) begin
            stalls++;
            cyc();
            #1;
        end
    endtask

    task automatic finish_branch();
        cyc();
        issue_valid = 1'b0;
        issue_kind  = K_OTHER;
        #1;
        chk("R7 valid cleared after consume", int'(result_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int st;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 valid after reset", int'(result_valid), 0);
        chk("R1 result after reset", int'(or_result), 0);
        issue_valid = 1'b1;
        issue_kind  = K_BRANCH;
        #1;
        chk("R1 no stall after reset", int'(issue_stall), 0);
        issue_valid = 1'b0;
        cyc();

        // table-driven: latency, stall count and OR value (R2, R3, R4)
        for (int v = 0; v < NV; v++) begin
            start_reduce(VEC[v].d, VEC[v].r, VEC[v].bits);
            wait_branch(st);
            chk("R4 stall count", st, int'(VEC[v].d) + 1 + int'(VEC[v].r));
            chk("R3 valid at release", int'(result_valid), 1);
            chk("R2 or value", int'(or_result), int'(VEC[v].hit));
            finish_branch();
        end

        // R5: other-kind instructions fill the wait
        start_reduce(4'd2, 4'd3, 16'h0004);
        for (int k = 0; k < 3; k++) begin
            issue_kind = (k == 1) ? K_SPARE : K_OTHER;
            #1;
            chk("R5 other not stalled", int'(issue_stall), 0);
            cyc();
        end
        wait_branch(st);
        chk("R5 remaining stall after fill", st, 3);
        chk("R2 or value after fill", int'(or_result), 1);
        finish_branch();

        // R6: second reduce waits until the first is consumed
        start_reduce(4'd0, 4'd1, 16'h0000);
        issue_kind = K_REDUCE;
        #1;
        chk("R6 reduce stalled while pending", int'(issue_stall), 1);
        cyc(); cyc(); cyc();
        #1;
        chk("R3 valid held until consumed", int'(result_valid), 1);
        chk("R6 reduce stalled while unconsumed", int'(issue_stall), 1);
        issue_kind = K_BRANCH;
        #1;
        chk("R4 branch free when valid", int'(issue_stall), 0);
        cyc();
        start_reduce(4'd0, 4'd1, 16'h0020);
        wait_branch(st);
        chk("R6 new reduce wait", st, 2);
        chk("R2 new reduce value", int'(or_result), 1);
        finish_branch();

        // R9: bits sampled at completion, not at issue
        start_reduce(4'd1, 4'd2, 16'hFFFF);
        pe_bits = 16'h0000;
        wait_branch(st);
        chk("R9 late clear sampled", int'(or_result), 0);
        finish_branch();
        start_reduce(4'd1, 4'd2, 16'h0000);
        pe_bits = 16'h0200;
        wait_branch(st);
        chk("R9 late set sampled", int'(or_result), 1);
        finish_branch();

        // R3: configuration captured at acceptance
        start_reduce(4'd0, 4'd2, 16'h0000);
        cfg_depth      = 4'd15;
        cfg_red_cycles = 4'd15;
        wait_branch(st);
        chk("R3 config captured at issue", st, 3);
        chk("R2 zero result means none enabled", int'(or_result), 0);
        finish_branch();

        // R7 and R8: held result, idle branch inert
        start_reduce(4'd0, 4'd0, 16'h0001);
        wait_branch(st);
        chk("R4 minimal wait", st, 1);
        finish_branch();
        chk("R7 result held after consume", int'(or_result), 1);
        issue_valid = 1'b1;
        issue_kind  = K_BRANCH;
        pe_bits     = 16'h0000;
        #1;
        chk("R8 idle branch not stalled", int'(issue_stall), 0);
        cyc(); cyc();
        #1;
        chk("R8 idle branch result unchanged", int'(or_result), 1);
        chk("R8 idle branch valid stays low", int'(result_valid), 0);
        issue_valid = 1'b0;
        cyc();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule